// File: doc/BRIEF.md
# Shared Write-Only Memory Page Selector

This block lets several memory boards that sit in the same window of address space take turns, so that total memory can grow past the window. Each board holds a small page register. Every board that has the feature enabled watches the bus for a write to one fixed I/O address. On such a write it takes a three-bit page number from bits 7..5 of the data word. A board whose own configured page equals the latched page raises a bank-active flag, and that flag gates its memory address decoder.

All enabled boards latch the page together, but only the one board with its reply option set answers the write on the bus. The others take the value silently. The address can only be written: a read of it is never answered by any board. The latched page is also handed out as a seven-bit field for the parity status register, so that software can read back what it wrote. When the feature is disabled the board acts as ordinary memory, with bank-active held high.

Top module: `bank_page_latch`

## Requirements
- R1: While `bus_init` is high at a clock edge, the latched page becomes 0 and `reply` becomes 0 after that edge.
- R2: A write (`wr_stb`=1) with `sel_en`=1 and `addr` equal to `SEL_ADDR` (default octal 17775100) loads `wdata[7:5]` into `page` at that clock edge.
- R3: `reply` is 1 in the cycle after such a write only if `reply_en` is 1; a board with `reply_en`=0 still latches but keeps `reply` at 0.
- R4: A read (`rd_stb`=1, `wr_stb`=0) at `SEL_ADDR` never sets `reply` and leaves `page` unchanged.
- R5: A write to any address other than `SEL_ADDR` leaves `page` unchanged and does not set `reply`.
- R6: With `sel_en`=0, writes to `SEL_ADDR` change nothing, `reply` stays 0 and `bank_active` is 1.
- R7: The board's own page is the bitwise inverse of `page_cfg`, where a 1 bit means "plug on" and stands for a 0: `page_cfg`=3'b111 gives page 0 and 3'b000 gives page 7.
- R8: With `sel_en`=1, `bank_active` is 1 exactly when the latched page equals the own page. It follows `page` in the same cycle.
- R9: `csr_mirror[2:0]` equals the latched page and `csr_mirror[6:3]` is 0. Bit 0 of this field lands at bit 5 of the parity status register.
- R10: Data bits other than 7..5 have no effect on the latched page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| bus_init | input | 1 | Synchronous bus initialise |
| addr | input | 22 | Bus address of the current transfer |
| wdata | input | 16 | Write data |
| wr_stb | input | 1 | Write strobe |
| rd_stb | input | 1 | Read strobe |
| sel_en | input | 1 | Page selection feature enable |
| reply_en | input | 1 | This board answers page writes |
| page_cfg | input | 3 | Own page, 1 = plug on = 0 bit |
| reply | output | 1 | Reply request for the bus |
| page | output | 3 | Latched page number |
| csr_mirror | output | 7 | Page field for parity register bits 11..5 |
| bank_active | output | 1 | This board's bank is selected |

## Verification
`page` and `reply` are registered, so both are due one clock edge after the strobe that caused them. `bank_active` and `csr_mirror` are combinational from `page`, so they change at that same edge. The bench drives each transfer at a falling edge and waits through one rising edge. It then samples every output at the next falling edge and compares it with a behavioural model that was advanced for that same edge. Two instances share one set of bus signals, so each comparison also shows that both boards latched the same page while only the reply-enabled board answered.

// File: rtl/bsel_pkg.sv
package bsel_pkg;
    localparam int PAGE_W = 3;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic              reply;
    } bsel_state_t;
endpackage

// File: rtl/bsel_decode.sv
module bsel_decode #(
    parameter int          ADDR_W   = 22,
    parameter logic [21:0] SEL_ADDR = 22'o17775100
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_stb,
    input  logic              sel_en,
    output logic              wr_hit
);
    localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(SEL_ADDR);

    // Only write transfers are decoded; the register cannot be read.
    always_comb begin
        wr_hit = sel_en && wr_stb && (addr == MATCH);
    end
endmodule

// File: rtl/bsel_match.sv
module bsel_match #(
    parameter int PAGE_W = 3
) (
    input  logic [PAGE_W-1:0] page_q,
    input  logic [PAGE_W-1:0] page_cfg,
    input  logic              sel_en,
    output logic              bank_active
);
    logic [PAGE_W-1:0] own_page;

    always_comb begin
        own_page    = ~page_cfg;                 // plug on reads as 0 (R7)
        bank_active = !sel_en || (page_q == own_page);
    end
endmodule

// File: rtl/bank_page_latch.sv
module bank_page_latch
    import bsel_pkg::*;
#(
    parameter int          ADDR_W   = 22,
    parameter int          DATA_W   = 16,
    parameter int          PAGE_LSB = 5,
    parameter int          MIRROR_W = 7,
    parameter logic [21:0] SEL_ADDR = 22'o17775100
) (
    input  logic              clk,
    input  logic              bus_init,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic              sel_en,
    input  logic              reply_en,
    input  logic [PAGE_W-1:0] page_cfg,
    output logic              reply,
    output logic [PAGE_W-1:0] page,
    output logic [MIRROR_W-1:0] csr_mirror,
    output logic              bank_active
);
    localparam int PAGE_MSB = PAGE_LSB + PAGE_W - 1;

    logic        wr_hit;
    bsel_state_t st_d, st_q;

    bsel_decode #(.ADDR_W(ADDR_W), .SEL_ADDR(SEL_ADDR)) u_dec (
        .addr   (addr),
        .wr_stb (wr_stb),
        .sel_en (sel_en),
        .wr_hit (wr_hit)
    );

    always_comb begin
        st_d       = st_q;
        st_d.reply = wr_hit && reply_en;
        if (wr_hit) st_d.page = wdata[PAGE_MSB:PAGE_LSB];
        if (bus_init) begin
            st_d.page  = '0;
            st_d.reply = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    bsel_match #(.PAGE_W(PAGE_W)) u_match (
        .page_q      (st_q.page),
        .page_cfg    (page_cfg),
        .sel_en      (sel_en),
        .bank_active (bank_active)
    );

    assign reply      = st_q.reply;
    assign page       = st_q.page;
    assign csr_mirror = {{(MIRROR_W-PAGE_W){1'b0}}, st_q.page};

    logic unused_bits;
    assign unused_bits = ^{wdata[DATA_W-1:PAGE_MSB+1], wdata[PAGE_LSB-1:0]};

    a_r2_page_loads: assert property (@(posedge clk) disable iff (bus_init)
        (sel_en && wr_stb && addr == ADDR_W'(SEL_ADDR)) |=> (page == $past(wdata[PAGE_MSB:PAGE_LSB])));

    a_r3_reply_needs_option: assert property (@(posedge clk) disable iff (bus_init)
        !reply_en |=> !reply);

    a_r4_read_unanswered: assert property (@(posedge clk) disable iff (bus_init)
        (rd_stb && !wr_stb) |=> (!reply && $stable(page)));

    a_r6_disabled_quiet: assert property (@(posedge clk) disable iff (bus_init)
        !sel_en |=> (!reply && $stable(page)));

    a_r6_disabled_active: assert property (@(posedge clk) disable iff (bus_init)
        !sel_en |-> bank_active);
endmodule

// File: tb/sim_bank_page_latch.sv
module sim_bank_page_latch;
    localparam int CLK_PERIOD = 10;
    localparam logic [21:0] SEL = 22'o17775100;

    logic        clk = 1'b0;
    logic        bus_init;
    logic [21:0] addr;
    logic [15:0] wdata;
    logic        wr_stb, rd_stb, sel_en;
    logic        reply0, reply1, act0, act1;
    logic [2:0]  page0, page1;
    logic [6:0]  mir0, mir1;

    int checks = 0;
    int fails  = 0;
    int exp_page;
    int exp_rep;
    int own0 = 2;
    int own1 = 5;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bank_page_latch u0 (
        .clk(clk), .bus_init(bus_init), .addr(addr), .wdata(wdata),
        .wr_stb(wr_stb), .rd_stb(rd_stb), .sel_en(sel_en), .reply_en(1'b1),
        .page_cfg(3'b101), .reply(reply0), .page(page0), .csr_mirror(mir0),
        .bank_active(act0));

    bank_page_latch u1 (
        .clk(clk), .bus_init(bus_init), .addr(addr), .wdata(wdata),
        .wr_stb(wr_stb), .rd_stb(rd_stb), .sel_en(sel_en), .reply_en(1'b0),
        .page_cfg(3'b010), .reply(reply1), .page(page1), .csr_mirror(mir1),
        .bank_active(act1));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic compare(input string req);
        int en = (sel_en === 1'b1) ? 1 : 0;
        chk({req, " page u0"}, int'(page0), exp_page);
        chk({req, " page u1 same"}, int'(page1), exp_page);
        chk({req, " reply u0"}, int'(reply0), exp_rep);
        chk({req, " reply u1 silent R3"}, int'(reply1), 0);
        chk({req, " mirror R9"}, int'(mir0), exp_page);
        chk({req, " active u0 R8"}, int'(act0), (!en || exp_page == own0) ? 1 : 0);
        chk({req, " active u1 R8"}, int'(act1), (!en || exp_page == own1) ? 1 : 0);
    endtask

    // one bus cycle: drive at falling edge, model the rising edge, check at next fall
    task automatic cyc(input string req, input bit ini, input bit en, input bit wr,
                       input bit rd, input logic [21:0] a, input logic [15:0] d);
        bus_init = ini; sel_en = en; wr_stb = wr; rd_stb = rd; addr = a; wdata = d;
        if (ini) begin
            exp_page = 0; exp_rep = 0;
        end else begin
            exp_rep = (en && wr && a == SEL) ? 1 : 0;
            if (en && wr && a == SEL) exp_page = int'(d[7:5]);
        end
        @(posedge clk);
        @(negedge clk);
        compare(req);
    endtask

    initial begin
        bus_init = 1; sel_en = 1; wr_stb = 0; rd_stb = 0; addr = '0; wdata = '0;
        exp_page = 0; exp_rep = 0;
        @(negedge clk);
        cyc("R1 reset", 1, 1, 0, 0, '0, '0);
        cyc("R1 idle", 0, 1, 0, 0, '0, '0);
        // R7: u0 cfg 101 -> own page 2, u1 cfg 010 -> own page 5
        cyc("R2 write page2", 0, 1, 1, 0, SEL, 16'h0040);
        cyc("R2 hold", 0, 1, 0, 0, '0, '0);
        cyc("R2 write page5", 0, 1, 1, 0, SEL, 16'h00A0);
        cyc("R10 other bits set page0", 0, 1, 1, 0, SEL, 16'hFF1F);
        cyc("R2 write page7", 0, 1, 1, 0, SEL, 16'h00E0);
        cyc("R4 read", 0, 1, 0, 1, SEL, 16'h0040);
        cyc("R5 other address", 0, 1, 1, 0, SEL + 22'd2, 16'h0040);
        cyc("R5 other address low", 0, 1, 1, 0, 22'o00100, 16'h0020);
        cyc("R6 disabled write", 0, 0, 1, 0, SEL, 16'h0040);
        cyc("R6 disabled idle", 0, 0, 0, 0, '0, '0);
        cyc("R3 back to back a", 0, 1, 1, 0, SEL, 16'h0020);
        cyc("R3 back to back b", 0, 1, 1, 0, SEL, 16'h00A0);
        cyc("R1 reinit", 1, 1, 0, 0, '0, '0);
        cyc("R7 page0", 0, 1, 0, 0, '0, '0);
        for (int p = 0; p < 8; p++) begin
            cyc("R8 sweep", 0, 1, 1, 0, SEL, 16'(p << 5));
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule